// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the address of a memory operand written as displacement plus base plus scaled index. The base and index come from register values, each with its own present flag; the displacement is a constant taken from the instruction. The index is multiplied by 1, 2, 4 or 8 through a left shift selected by a 2-bit code. In relative mode, the address of the following instruction takes the place of the base, so code can reach its globals wherever it is loaded.

Each request arrives with an input valid strobe. One clock later the 64-bit sum appears with an output valid strobe. The sum also carries a flag that says whether the consumer should use it as an address to read, or take it directly as a data result. The second case gives a one-operation form of expressions such as a + 2·b. The unit does not perform the memory access itself.

Top module: `ea_gen`

## Requirements
- R1: The result equals the sign-extended displacement plus the base term plus the scaled index term, where the base term is `baseVal` when `baseEn` is 1 and the index term is `indexVal` scaled when `indexEn` is 1.
- R2: `scaleCode` values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively (a left shift by the code).
- R3: An absent base or index contributes zero regardless of the value on its data input, and `scaleCode` has no effect when `indexEn` is 0.
- R4: `disp` is a 32-bit two's-complement value, sign-extended to 64 bits before the addition, so negative displacements subtract.
- R5: The addition wraps modulo 2^64 and no overflow indication exists.
- R6: `outValid` is 1 in exactly the cycle after each cycle in which `inValid` is 1, and 0 otherwise; back-to-back requests each produce a result.
- R7: When `ripMode` is 1, `nextPc` is used in place of the base term; `baseEn` and `baseVal` are then ignored, even when `baseEn` is 1.
- R8: `outIsValue` presents, together with each result, the `addrOnly` value of the request that produced it (1 = use the sum as a data result, 0 = use it as an address to read).
- R9: After reset `outValid`, `effAddr` and `outIsValue` are 0; in cycles with no request, `effAddr` and `outIsValue` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe for the operand fields this cycle |
| baseEn | input | 1 | Base register present |
| baseVal | input | 64 | Base register value |
| indexEn | input | 1 | Index register present |
| indexVal | input | 64 | Index register value |
| scaleCode | input | 2 | Index shift amount 0..3 |
| disp | input | 32 | Signed displacement from the instruction |
| ripMode | input | 1 | Use next-instruction address as base |
| nextPc | input | 64 | Address of the following instruction |
| addrOnly | input | 1 | Result is a data value, not an address to read |
| outValid | output | 1 | Result strobe |
| effAddr | output | 64 | Computed sum |
| outIsValue | output | 1 | Copy of `addrOnly` for this result |

## Verification
Every cycle, the assertions check the one-cycle valid latency, the holding of outputs when idle, and the transfer of the value flag. They also check the sum in the cases that need no scaled index: displacement-only and relative mode. The scoreboard covers the rest of the arithmetic: each scale code, ignored base and index data, negative displacement, wrap past 2^64, and relative mode overriding a present base. Randomly mixed requests, including back-to-back strobes, can only be judged against the bench's own model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef struct packed {
    logic load;
    logic useRip;
    logic useBase;
    logic useIndex;
  } ea_strb_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     baseEn,
  input  logic     indexEn,
  input  logic     ripMode,
  output ea_strb_t strb,
  output logic     outValid
);
  // relative mode wins over an explicit base
  always_comb begin
    strb.load     = inValid;
    strb.useRip   = ripMode;
    strb.useBase  = baseEn & ~ripMode;
    strb.useIndex = indexEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ea_strb_t           strb,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [DISP_W-1:0]  disp,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic               addrOnly,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               outIsValue
);
  localparam int NSCALE = 1 << SCALE_W;
  localparam int EXT_W  = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] shiftOpt [NSCALE];
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] sum;

  for (genvar s = 0; s < NSCALE; s++) begin : g_scale
    assign shiftOpt[s] = indexVal << s;
  end

  always_comb begin
    if (strb.useRip)       baseTerm = nextPc;
    else if (strb.useBase) baseTerm = baseVal;
    else                   baseTerm = '0;
    indexTerm = strb.useIndex ? shiftOpt[scaleCode] : '0;
    dispExt   = {{EXT_W{disp[DISP_W-1]}}, disp};
    sum       = baseTerm + indexTerm + dispExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr    <= '0;
      outIsValue <= 1'b0;
    end else if (strb.load) begin
      effAddr    <= sum;
      outIsValue <= addrOnly;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               baseEn,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic               indexEn,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [DISP_W-1:0]  disp,
  input  logic               ripMode,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic               addrOnly,
  output logic               outValid,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               outIsValue
);
  ea_strb_t strb;

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .baseEn   (baseEn),
    .indexEn  (indexEn),
    .ripMode  (ripMode),
    .strb     (strb),
    .outValid (outValid)
  );

  ea_datapath #(
    .ADDR_W  (ADDR_W),
    .DISP_W  (DISP_W),
    .SCALE_W (SCALE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .baseVal    (baseVal),
    .indexVal   (indexVal),
    .scaleCode  (scaleCode),
    .disp       (disp),
    .nextPc     (nextPc),
    .addrOnly   (addrOnly),
    .effAddr    (effAddr),
    .outIsValue (outIsValue)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               baseEn,
  input logic [ADDR_W-1:0]  baseVal,
  input logic               indexEn,
  input logic [ADDR_W-1:0]  indexVal,
  input logic [SCALE_W-1:0] scaleCode,
  input logic [DISP_W-1:0]  disp,
  input logic               ripMode,
  input logic [ADDR_W-1:0]  nextPc,
  input logic               addrOnly,
  input logic               outValid,
  input logic [ADDR_W-1:0]  effAddr,
  input logic               outIsValue
);
  localparam int EXT_W = ADDR_W - DISP_W;

  function automatic logic [ADDR_W-1:0] sext(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(effAddr) && $stable(outIsValue)));

  p_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outIsValue == $past(addrOnly)));

  // R3 and R4: with nothing present, only the extended displacement remains
  p_disp_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !baseEn && !indexEn && !ripMode) |=> (effAddr == sext($past(disp))));

  p_rel_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ripMode && !indexEn) |=> (effAddr == $past(nextPc) + sext($past(disp))));

  // unused in properties but kept visible to the bind
  logic unusedSink;
  assign unusedSink = ^{baseVal, indexVal, scaleCode};
endmodule

bind ea_gen ea_gen_chk #(
  .ADDR_W  (ADDR_W),
  .DISP_W  (DISP_W),
  .SCALE_W (SCALE_W)
) u_chk (.*);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  typedef struct {
    logic [63:0] addr;
    logic        isVal;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, baseEn = 1'b0, indexEn = 1'b0, ripMode = 1'b0, addrOnly = 1'b0;
  logic [63:0] baseVal = '0, indexVal = '0, nextPc = '0;
  logic [1:0]  scaleCode = '0;
  logic [31:0] disp = '0;
  logic        outValid, outIsValue;
  logic [63:0] effAddr;

  int    testCnt = 0;
  int    failCnt = 0;
  exp_t  expQ[$];
  logic [63:0] lastAddr = '0;
  logic        lastFlag = 1'b0;
  logic        running = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ea_gen u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model: multiply rather than shift, explicit sign handling
  task automatic send(input string tag, input bit bEn, input logic [63:0] b,
                      input bit iEn, input logic [63:0] ix, input logic [1:0] sc,
                      input logic [31:0] d, input bit rel, input logic [63:0] pc,
                      input bit ao, input bit keep = 0);
    exp_t e;
    logic [63:0] baseT, idxT, dT;
    @(negedge clk);
    inValid = 1'b1; baseEn = bEn; baseVal = b; indexEn = iEn; indexVal = ix;
    scaleCode = sc; disp = d; ripMode = rel; nextPc = pc; addrOnly = ao;
    baseT = rel ? pc : (bEn ? b : 64'd0);
    idxT  = iEn ? ix * (64'd1 << sc) : 64'd0;
    dT    = d[31] ? (64'hFFFF_FFFF_0000_0000 | {32'd0, d}) : {32'd0, d};
    e.addr = baseT + idxT + dT;
    e.isVal = ao;
    e.tag = tag;
    expQ.push_back(e);
    if (!keep) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        exp_t e;
        if (expQ.size() == 0) begin
          check("R6 unexpected result", 64'd1, 64'd0);
        end else begin
          e = expQ.pop_front();
          check(e.tag, effAddr, e.addr);
          check({e.tag, " R8 flag"}, {63'd0, outIsValue}, {63'd0, e.isVal});
        end
        lastAddr = effAddr;
        lastFlag = outIsValue;
      end else begin
        check("R9 hold addr", effAddr, lastAddr);
        check("R9 hold flag", {63'd0, outIsValue}, {63'd0, lastFlag});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outValid", {63'd0, outValid}, 64'd0);
    check("R9 reset effAddr", effAddr, 64'd0);
    check("R9 reset flag", {63'd0, outIsValue}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;

    send("R1 full form", 1, 64'h1000, 1, 64'h10, 2'd2, 32'h18, 0, 64'h0, 0);
    for (int s = 0; s < 4; s++)
      send("R2 scale", 0, 64'h0, 1, 64'h0123_4567, s[1:0], 32'h0, 0, 64'h0, 0);
    send("R3 base absent", 0, 64'hDEAD_BEEF, 1, 64'h40, 2'd0, 32'h4, 0, 64'h0, 0);
    send("R3 index absent", 1, 64'h8000, 0, 64'hFFFF_0000, 2'd3, 32'h0, 0, 64'h0, 0);
    send("R3 none present", 0, 64'h55, 0, 64'h66, 2'd1, 32'h7, 0, 64'h0, 0);
    send("R4 negative disp", 1, 64'h2000, 0, 64'h0, 2'd0, 32'hFFFF_FFF0, 0, 64'h0, 0);
    send("R4 min disp", 0, 64'h0, 0, 64'h0, 2'd0, 32'h8000_0000, 0, 64'h0, 0);
    send("R5 wrap", 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'h8000_0000_0000_0000, 2'd1, 32'h2, 0, 64'h0, 0);
    send("R7 rel mode", 0, 64'h0, 0, 64'h0, 2'd0, 32'hF80, 1, 64'h40_0080, 0);
    send("R7 rel overrides base", 1, 64'h1234_0000, 0, 64'h0, 2'd0, 32'hF80, 1, 64'h40_4080, 0);
    send("R7 rel with index", 1, 64'h9999, 1, 64'h3, 2'd3, 32'h10, 1, 64'h40_0470, 0);
    send("R8 value a+2b", 1, 64'd100, 1, 64'd7, 2'd1, 32'h0, 0, 64'h0, 1);
    repeat (3) @(negedge clk);
    // R6 back-to-back strobes
    send("R6 burst0", 1, 64'h10, 0, 64'h0, 2'd0, 32'h1, 0, 64'h0, 1, 1);
    send("R6 burst1", 1, 64'h20, 1, 64'h2, 2'd2, 32'h2, 0, 64'h0, 0, 1);
    send("R6 burst2", 0, 64'h30, 0, 64'h0, 2'd0, 32'h3, 1, 64'h500, 1);
    for (int k = 0; k < 40; k++)
      send("R1 random", $urandom_range(0, 1) == 1, {$urandom, $urandom},
           $urandom_range(0, 1) == 1, {$urandom, $urandom}, 2'($urandom_range(0, 3)),
           $urandom, $urandom_range(0, 3) == 0, {$urandom, $urandom},
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    @(negedge clk);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 all results delivered", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule